// File: doc/BRIEF.md
# SPI Slave Frame Error Monitor

This block watches the slave side of an SPI link and judges every transaction. Its inputs are already synchronized into the local engine clock. A transaction, or frame, is the interval during which the active-low slave select is held low. During a frame the monitor counts serial-clock edge pulses against the configured word size. It notes whether transmit data was ready each time a new word began. It also times the silence between serial clocks. When the frame closes it raises a length error if the frame did not end on a word boundary, or if it carried no clocks at all. It raises an under-run error if a word started without transmit data.

An inactivity time-out can be armed independently by programming a non-zero limit. Once clocking has begun, a counter measures the cycles since the most recent serial-clock pulse. If that count reaches the limit while a word is only partly shifted, the time-out flag is raised. All three flags stay set until software clears them, each with its own one-cycle clear strobe.

Top module: `spi_slv_err_chk`

## Requirements
- R1: When `ssel_n` rises after a frame, `err_len` is set on the following cycle if the number of `sclk_pls` pulses in the frame is not a multiple of `cfg_width` (valid range 8 to 32).
- R2: A frame that contains no `sclk_pls` pulse at all sets `err_len` when `ssel_n` rises.
- R3: A pulse that begins a word (the pulses counted so far in the frame are a multiple of `cfg_width`) while `tx_avail` is 0 marks an under-run. `err_udr` is set on the cycle after `ssel_n` rises, and never while the frame is still open.
- R4: With `cfg_tmo` = L > 0, consider a pulse that leaves a word incomplete. If the next pulse arrives d cycles later with d >= L+1, `err_tmo` is set. If instead `ssel_n` rises d cycles later with d >= L+2, `err_tmo` is also set. Shorter gaps leave it clear.
- R5: No time-out is flagged in a gap that follows a pulse completing a word, nor before the first pulse of a frame.
- R6: `cfg_tmo` = 0 disables the time-out entirely.
- R7: Each flag is sticky. Its clear strobe (`clr_len`, `clr_udr`, `clr_tmo`) clears it on the next cycle. A new error in the same cycle as the strobe wins over the clear.
- R8: `sclk_pls` and `tx_avail` are ignored while `ssel_n` is high. Pulses there neither count toward the next frame nor cause an under-run.
- R9: After synchronous reset `rst` all three flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst | input | 1 | Synchronous active-high reset |
| ssel_n | input | 1 | Synchronized slave select, low = frame active |
| sclk_pls | input | 1 | One-cycle pulse per serial-clock period |
| tx_avail | input | 1 | Transmit data ready for the next word |
| cfg_width | input | 6 | Word size in bits, 8 to 32 |
| cfg_tmo | input | 16 | Inactivity limit in engine cycles, 0 = off |
| clr_len | input | 1 | Clear strobe for err_len |
| clr_udr | input | 1 | Clear strobe for err_udr |
| clr_tmo | input | 1 | Clear strobe for err_tmo |
| err_len | output | 1 | Sticky frame length error |
| err_udr | output | 1 | Sticky transmit under-run error |
| err_tmo | output | 1 | Sticky inactivity time-out |

## Verification
The bound assertions check these properties on every cycle:
- the length and under-run flags rise only on the cycle after slave select is released;
- the time-out flag rises only inside a frame with a non-zero limit;
- the flags hold until their strobe;
- a strobe clears its flag whenever no new error can coincide with it.

Only the bench's frames can show that the flags take the right values. These frames cover pulse counts on and off word boundaries, gaps exactly at and one below the time-out threshold, under-runs placed at word starts versus mid-word, and stray pulses between frames.

// File: rtl/spi_chk_pkg.sv
package spi_chk_pkg;
    localparam int WCNT_W = 6;
    localparam int TMO_W  = 16;

    typedef struct packed {
        logic len;
        logic udr;
        logic tmo;
    } err_flags_t;

    typedef struct packed {
        logic              active;
        logic              release_ev;
        logic              seen;
        logic              word_open;
        logic              udr_pend;
    } frame_state_t;

    // Next value of the bit position inside a word, wrapping at the word size.
    function automatic logic [WCNT_W-1:0] bit_next(input logic [WCNT_W-1:0] cur,
                                                   input logic [WCNT_W-1:0] width);
        logic [WCNT_W-1:0] inc;
        inc = cur + 1'b1;
        return (inc == width) ? '0 : inc;
    endfunction
endpackage

// File: rtl/spi_frame_track.sv
module spi_frame_track
    import spi_chk_pkg::*;
#(
    parameter int CW = WCNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ssel_n,
    input  logic          sclk_pls,
    input  logic          tx_avail,
    input  logic [CW-1:0] cfg_width,
    output frame_state_t  fs
);
    logic          act_q;
    logic          seen_q;
    logic          udr_q;
    logic [CW-1:0] pos_q;
    logic          act;

    assign act = ~ssel_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            seen_q <= 1'b0;
            udr_q  <= 1'b0;
            pos_q  <= '0;
        end else begin
            act_q <= act;
            if (!act) begin
                seen_q <= 1'b0;
                udr_q  <= 1'b0;
                pos_q  <= '0;
            end else if (sclk_pls) begin
                seen_q <= 1'b1;
                pos_q  <= bit_next(pos_q, cfg_width);
                if (pos_q == '0 && !tx_avail)
                    udr_q <= 1'b1;
            end
        end
    end

    always_comb begin
        fs.active     = act;
        fs.release_ev = act_q & ~act;
        fs.seen       = seen_q;
        fs.word_open  = (pos_q != '0);
        fs.udr_pend   = udr_q;
    end
endmodule

// File: rtl/spi_tmo_timer.sv
module spi_tmo_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic          seen,
    input  logic          word_open,
    input  logic          sclk_pls,
    input  logic [TW-1:0] cfg_tmo,
    output logic          hit
);
    logic [TW-1:0] cnt_q;
    logic          run;

    assign run = active & seen & (cfg_tmo != '0);

    always_ff @(posedge clk) begin
        if (rst || !active || sclk_pls)
            cnt_q <= '0;
        else if (run && cnt_q != '1)
            cnt_q <= cnt_q + 1'b1;
    end

    assign hit = run & word_open & (cnt_q >= cfg_tmo);
endmodule

// File: rtl/spi_slv_err_chk.sv
module spi_slv_err_chk
    import spi_chk_pkg::*;
#(
    parameter int CW = WCNT_W,
    parameter int TW = TMO_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ssel_n,
    input  logic          sclk_pls,
    input  logic          tx_avail,
    input  logic [CW-1:0] cfg_width,
    input  logic [TW-1:0] cfg_tmo,
    input  logic          clr_len,
    input  logic          clr_udr,
    input  logic          clr_tmo,
    output logic          err_len,
    output logic          err_udr,
    output logic          err_tmo
);
    frame_state_t fs;
    logic         tmo_hit;
    err_flags_t   flg_q, flg_d;

    spi_frame_track #(.CW(CW)) u_track (
        .clk      (clk),
        .rst      (rst),
        .ssel_n   (ssel_n),
        .sclk_pls (sclk_pls),
        .tx_avail (tx_avail),
        .cfg_width(cfg_width),
        .fs       (fs)
    );

    spi_tmo_timer #(.TW(TW)) u_tmo (
        .clk      (clk),
        .rst      (rst),
        .active   (fs.active),
        .seen     (fs.seen),
        .word_open(fs.word_open),
        .sclk_pls (sclk_pls),
        .cfg_tmo  (cfg_tmo),
        .hit      (tmo_hit)
    );

    always_comb begin
        flg_d.len = (flg_q.len & ~clr_len)
                  | (fs.release_ev & (~fs.seen | fs.word_open));
        flg_d.udr = (flg_q.udr & ~clr_udr) | (fs.release_ev & fs.udr_pend);
        flg_d.tmo = (flg_q.tmo & ~clr_tmo) | tmo_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) flg_q <= '0;
        else     flg_q <= flg_d;
    end

    assign err_len = flg_q.len;
    assign err_udr = flg_q.udr;
    assign err_tmo = flg_q.tmo;
endmodule

// File: rtl/spi_slv_err_chk_sva.sv
module spi_slv_err_chk_sva #(
    parameter int TW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          ssel_n,
    input logic [TW-1:0] cfg_tmo,
    input logic          clr_len,
    input logic          clr_udr,
    input logic          clr_tmo,
    input logic          err_len,
    input logic          err_udr,
    input logic          err_tmo
);
    p_len_at_release_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(err_len) |-> ($past(ssel_n) && !$past(ssel_n, 2)));

    p_udr_at_release_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(err_udr) |-> ($past(ssel_n) && !$past(ssel_n, 2)));

    p_tmo_in_frame_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(err_tmo) |-> ($past(cfg_tmo) != '0 && !$past(ssel_n)));

    p_len_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (clr_len && !ssel_n) |=> !err_len);

    p_udr_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (clr_udr && !ssel_n) |=> !err_udr);

    p_tmo_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (clr_tmo && ssel_n) |=> !err_tmo);

    p_len_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (err_len && !clr_len) |=> err_len);

    p_tmo_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (err_tmo && !clr_tmo) |=> err_tmo);
endmodule

bind spi_slv_err_chk spi_slv_err_chk_sva #(.TW(TW)) u_sva (
    .clk(clk), .rst(rst), .ssel_n(ssel_n), .cfg_tmo(cfg_tmo),
    .clr_len(clr_len), .clr_udr(clr_udr), .clr_tmo(clr_tmo),
    .err_len(err_len), .err_udr(err_udr), .err_tmo(err_tmo)
);

// File: tb/spi_slv_err_chk_test.sv
module spi_slv_err_chk_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ssel_n = 1'b1;
    logic        sclk_pls = 1'b0;
    logic        tx_avail = 1'b1;
    logic [5:0]  cfg_width = 6'd8;
    logic [15:0] cfg_tmo = 16'd0;
    logic        clr_len = 1'b0, clr_udr = 1'b0, clr_tmo = 1'b0;
    logic        err_len, err_udr, err_tmo;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state for the current frame
    int  m_cnt;
    int  m_gap;
    bit  m_seen, m_udr, m_tmo;

    always #10 clk = ~clk;

    spi_slv_err_chk uut (
        .clk(clk), .rst(rst), .ssel_n(ssel_n), .sclk_pls(sclk_pls),
        .tx_avail(tx_avail), .cfg_width(cfg_width), .cfg_tmo(cfg_tmo),
        .clr_len(clr_len), .clr_udr(clr_udr), .clr_tmo(clr_tmo),
        .err_len(err_len), .err_udr(err_udr), .err_tmo(err_tmo)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // one engine cycle: drive at negedge, sampled at the next posedge
    task automatic cyc(input logic ss, input logic pl, input logic tx);
        ssel_n = ss; sclk_pls = pl; tx_avail = tx;
        @(negedge clk);
        ssel_n = ss; sclk_pls = 1'b0; tx_avail = 1'b1;
    endtask

    function automatic bit tmo_gap(input int d, input int lim, input bit open, input bit tail);
        if (lim == 0 || !open) return 0;
        return tail ? (d >= lim + 2) : (d >= lim + 1);
    endfunction

    task automatic frame_begin();
        m_cnt = 0; m_seen = 0; m_udr = 0; m_tmo = 0; m_gap = 0;
        cyc(1'b0, 1'b0, 1'b1);
    endtask

    task automatic pulse(input int gap, input logic tx);
        int w;
        w = int'(cfg_width);
        for (int i = 0; i < gap; i++) cyc(1'b0, 1'b0, 1'b1);
        if (m_seen && tmo_gap(gap + 1, int'(cfg_tmo), (m_cnt % w) != 0, 1'b0)) m_tmo = 1;
        if ((m_cnt % w) == 0 && !tx) m_udr = 1;
        cyc(1'b0, 1'b1, tx);
        m_cnt++; m_seen = 1;
    endtask

    task automatic frame_end(input int tail, input string tag);
        int w;
        bit exp_len;
        w = int'(cfg_width);
        for (int i = 0; i < tail; i++) cyc(1'b0, 1'b0, 1'b1);
        if (m_seen && tmo_gap(tail + 1, int'(cfg_tmo), (m_cnt % w) != 0, 1'b1)) m_tmo = 1;
        exp_len = !m_seen || (m_cnt % w) != 0;
        check({tag, " R3 no under-run before release"}, err_udr, 1'b0);
        cyc(1'b1, 1'b0, 1'b1);
        cyc(1'b1, 1'b0, 1'b1);
        check({tag, m_seen ? " R1 length" : " R2 empty frame"}, err_len, exp_len);
        check({tag, " R3 under-run"}, err_udr, m_udr);
        check({tag, (cfg_tmo == 0) ? " R6 time-out off" : " R4/R5 time-out"}, err_tmo, m_tmo);
        clr_len = 1; clr_udr = 1; clr_tmo = 1;
        cyc(1'b1, 1'b0, 1'b1);
        clr_len = 0; clr_udr = 0; clr_tmo = 0;
        check({tag, " R7 clear len"}, err_len, 1'b0);
        check({tag, " R7 clear udr"}, err_udr, 1'b0);
        check({tag, " R7 clear tmo"}, err_tmo, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        @(negedge clk); @(negedge clk);
        // R9: reset state
        check("R9 reset len", err_len, 1'b0);
        check("R9 reset udr", err_udr, 1'b0);
        check("R9 reset tmo", err_tmo, 1'b0);
        rst = 0;
        @(negedge clk);

        // R2: empty frame
        cfg_width = 6'd8; cfg_tmo = 16'd0;
        frame_begin(); frame_end(3, "empty");

        // R1: exact word then one extra
        frame_begin();
        for (int i = 0; i < 16; i++) pulse(1, 1'b1);
        frame_end(2, "two words");
        frame_begin();
        for (int i = 0; i < 17; i++) pulse(0, 1'b1);
        frame_end(2, "17 bits");

        // R3: under-run mid-word ignored, at word start flagged
        frame_begin();
        for (int i = 0; i < 8; i++) pulse(0, (i == 3) ? 1'b0 : 1'b1);
        frame_end(1, "tx low mid-word");
        frame_begin();
        for (int i = 0; i < 16; i++) pulse(0, (i == 8) ? 1'b0 : 1'b1);
        frame_end(1, "tx low word start");

        // R8: stray pulses with tx low while idle
        for (int i = 0; i < 5; i++) cyc(1'b1, 1'b1, 1'b0);
        frame_begin();
        for (int i = 0; i < 8; i++) pulse(0, 1'b1);
        frame_end(1, "R8 idle pulses ignored");

        // R4 thresholds with L = 5
        cfg_tmo = 16'd5;
        frame_begin();
        pulse(0, 1'b1); pulse(4, 1'b1);
        for (int i = 0; i < 6; i++) pulse(0, 1'b1);
        frame_end(0, "R4 gap L");
        frame_begin();
        pulse(0, 1'b1); pulse(5, 1'b1);
        for (int i = 0; i < 6; i++) pulse(0, 1'b1);
        frame_end(0, "R4 gap L+1");
        frame_begin();
        pulse(0, 1'b1); frame_end(5, "R4 tail L+1");
        frame_begin();
        pulse(0, 1'b1); frame_end(6, "R4 tail L+2");
        // R5: long gaps at word boundary and before first pulse
        frame_begin();
        for (int i = 0; i < 8; i++) pulse((i == 0) ? 20 : 0, 1'b1);
        frame_end(20, "R5 boundary gap");
        // R6: limit 0 with long gap
        cfg_tmo = 16'd0;
        frame_begin();
        pulse(0, 1'b1); frame_end(40, "R6 off");

        // R7: release with clear strobe in the same cycle: set wins
        cfg_tmo = 16'd0;
        frame_begin();
        pulse(0, 1'b1);
        clr_len = 1;
        cyc(1'b1, 1'b0, 1'b1);
        clr_len = 0;
        cyc(1'b1, 1'b0, 1'b1);
        check("R7 set beats clear", err_len, 1'b1);
        cyc(1'b1, 1'b0, 1'b1);
        check("R7 sticky", err_len, 1'b1);
        clr_len = 1; cyc(1'b1, 1'b0, 1'b1); clr_len = 0;
        check("R7 cleared", err_len, 1'b0);

        // random frames
        for (int f = 0; f < 120; f++) begin
            int w, nw, n, lim;
            w = 8 + int'($urandom % 25);
            cfg_width = 6'(w);
            lim = ($urandom % 3 == 0) ? 0 : 2 + int'($urandom % 6);
            cfg_tmo = 16'(lim);
            nw = int'($urandom % 3);
            n = nw * w + (($urandom % 2 == 0) ? 0 : int'($urandom % w));
            for (int i = 0; i < int'($urandom % 3); i++) cyc(1'b1, 1'($urandom % 2), 1'($urandom % 2));
            frame_begin();
            for (int i = 0; i < n; i++) begin
                int g;
                g = ($urandom % 16 == 0) ? lim + int'($urandom % 3) : int'($urandom % 3);
                pulse(g, ($urandom % 40 == 0) ? 1'b0 : 1'b1);
            end
            frame_end(($urandom % 8 == 0) ? lim + int'($urandom % 3) : int'($urandom % 3), "random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule